// File: doc/BRIEF.md
# Serial output expander controller

The block drives a chain of external 8-bit shift registers from a 24-bit host shadow word, so that three output pins can stand in for up to 24 parallel outputs. Software writes the shadow word and a configuration word through a small register port. Whenever the effective output word changes, the controller shifts it out on a shift clock and a data line, then pulses a store strobe so the external registers present the new bits on their outputs.

The chain may hold one, two or three byte groups; a group-enable mask says which of them are fitted, and only those are shifted. Some low bit positions can be taken over by on-chip hardware: two modem status lines and four 3-bit PHY status buses. Each takeover is enabled separately, and the hardware value then replaces the host bit in the effective word. The shift clock is derived from the system clock by a programmable half-period. A polarity bit chooses whether the data line changes on the falling edge (the default) or on the rising edge of the shift clock.

Top module: `sout_expander`

## Requirements
- R1: After reset the shadow word reads 24'hFFFFFF, the configuration word reads 24'h040007 (all three groups, falling-edge mode, no takeover, half-period 4), and no shift clock edge or store strobe occurs while the inputs stay unchanged.
- R2: A write to address 0 loads the shadow word, and a read of address 0 returns the effective word. Address 1 holds the configuration: bits [2:0] group enables (bit g is group g, which holds word bits 8g+7..8g), bit 3 polarity, bits [5:4] modem takeover, bits [9:6] PHY takeover, bits [23:16] half-period in system cycles. A half-period of 0 is stored and read back as 1. Address 2 reads zero.
- R3: When modem takeover bit i (i = 0,1) is set, effective bit i equals modem input i instead of shadow bit i.
- R4: When PHY takeover bit k (k = 0..3) is set, effective bits 2+3k..4+3k equal PHY input bits 3k..3k+2. Host writes to those positions do not change the effective word.
- R5: A change of the effective word starts a transfer. The enabled groups go out highest group first and MSB first, with 8 bits per enabled group, so after the strobe the external chain holds exactly the enabled bytes of the word.
- R6: Disabled groups are not shifted. With no group enabled, a change of the word produces no shift clock edge and no strobe.
- R7: Each bit lasts two half-periods. The data line changes only at the start of a bit and stays stable for at least a half-period before and after the capture edge. In polarity 0 the capture edge is rising and the idle level is low; in polarity 1 both are inverted.
- R8: After the last bit the store strobe is high for exactly two half-periods, and the shift clock stays at its idle level throughout.
- R9: If the word changes during a transfer, exactly one further transfer follows the strobe and carries the latest word; intermediate values are skipped.
- R10: Between transfers the shift clock rests at the idle level selected by the polarity bit and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational) |
| dsl_in | input | 2 | Modem status inputs for the two lowest bits |
| phy_in | input | 12 | PHY status inputs, 3 bits per PHY |
| shift_clk | output | 1 | Shift clock to the external chain |
| shift_data | output | 1 | Serial data to the external chain |
| store_strobe | output | 1 | Store strobe to the external chain |

## Verification
The assertions check on every cycle that the data line holds steady across each capture edge, and that the shift clock is idle while the strobe is high and between transfers. They also check that each strobe lasts two latched half-periods and that a transfer begins only when the effective word differs from the last word sent and at least one group is enabled. The bench's scenarios are needed to show what the external chain ends up holding, the group ordering, the takeover of bits by modem and PHY inputs, the clamped half-period, and the skipping of intermediate words when the word changes during a transfer.

// File: rtl/sout_pkg.sv
package sout_pkg;
    localparam int NUM_GROUPS = 3;
    localparam int GROUP_W    = 8;
    localparam int WORD_W     = NUM_GROUPS * GROUP_W;
    localparam int DSL_W      = 2;
    localparam int NUM_PHY    = 4;
    localparam int PHY_W      = 3;
    localparam int PHY_BASE   = DSL_W;
    localparam int HW_TOP     = PHY_BASE + NUM_PHY * PHY_W;
    localparam int DIV_W      = 8;
    localparam int ADDR_W     = 2;
    localparam int BCNT_W     = $clog2(WORD_W + 1);

    // configuration field positions inside the configuration register
    localparam int CFG_GRP_LSB  = 0;
    localparam int CFG_EDGE_BIT = CFG_GRP_LSB + NUM_GROUPS;
    localparam int CFG_DSL_LSB  = CFG_EDGE_BIT + 1;
    localparam int CFG_PHY_LSB  = CFG_DSL_LSB + DSL_W;
    localparam int CFG_HALF_LSB = 16;

    localparam logic [ADDR_W-1:0] ADDR_SHADOW = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG    = 2'd1;

    typedef struct packed {
        logic [DIV_W-1:0]      half;
        logic [NUM_PHY-1:0]    phy_en;
        logic [DSL_W-1:0]      dsl_en;
        logic                  edge_rise;
        logic [NUM_GROUPS-1:0] grp_en;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_STORE = 2'd2
    } eng_state_t;

    // Pack the enabled groups at the top of a word, highest group first.
    function automatic logic [WORD_W-1:0] pack_groups(input logic [WORD_W-1:0] word,
                                                      input logic [NUM_GROUPS-1:0] en);
        logic [WORD_W-1:0] res;
        int                slot;
        res  = '0;
        slot = 0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (en[g]) begin
                res[WORD_W - 1 - slot * GROUP_W -: GROUP_W] = word[g * GROUP_W +: GROUP_W];
                slot++;
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/sout_regs.sv
module sout_regs
    import sout_pkg::*;
#(
    parameter logic [WORD_W-1:0] SHADOW_RST = '1,
    parameter logic [DIV_W-1:0]  HALF_RST   = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] eff_word,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] shadow,
    output cfg_t              cfg
);
    typedef struct packed {
        logic [WORD_W-1:0] shadow;
        cfg_t              cfg;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (addr)
                ADDR_SHADOW: regs_d.shadow = wdata;
                ADDR_CFG: begin
                    regs_d.cfg.grp_en    = wdata[CFG_GRP_LSB +: NUM_GROUPS];
                    regs_d.cfg.edge_rise = wdata[CFG_EDGE_BIT];
                    regs_d.cfg.dsl_en    = wdata[CFG_DSL_LSB +: DSL_W];
                    regs_d.cfg.phy_en    = wdata[CFG_PHY_LSB +: NUM_PHY];
                    if (wdata[CFG_HALF_LSB +: DIV_W] == '0)
                        regs_d.cfg.half = DIV_W'(1);
                    else
                        regs_d.cfg.half = wdata[CFG_HALF_LSB +: DIV_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.shadow        <= SHADOW_RST;
            regs_q.cfg.grp_en    <= '1;
            regs_q.cfg.edge_rise <= 1'b0;
            regs_q.cfg.dsl_en    <= '0;
            regs_q.cfg.phy_en    <= '0;
            regs_q.cfg.half      <= (HALF_RST == '0) ? DIV_W'(1) : HALF_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_SHADOW: rdata = eff_word;
            ADDR_CFG: begin
                rdata[CFG_GRP_LSB +: NUM_GROUPS] = regs_q.cfg.grp_en;
                rdata[CFG_EDGE_BIT]              = regs_q.cfg.edge_rise;
                rdata[CFG_DSL_LSB +: DSL_W]      = regs_q.cfg.dsl_en;
                rdata[CFG_PHY_LSB +: NUM_PHY]    = regs_q.cfg.phy_en;
                rdata[CFG_HALF_LSB +: DIV_W]     = regs_q.cfg.half;
            end
            default: ;
        endcase
    end

    assign shadow = regs_q.shadow;
    assign cfg    = regs_q.cfg;
endmodule

// File: rtl/sout_mux.sv
module sout_mux
    import sout_pkg::*;
(
    input  logic [WORD_W-1:0]        shadow,
    input  logic [DSL_W-1:0]         dsl_en,
    input  logic [NUM_PHY-1:0]       phy_en,
    input  logic [DSL_W-1:0]         dsl_in,
    input  logic [NUM_PHY*PHY_W-1:0] phy_in,
    output logic [WORD_W-1:0]        eff_word
);
    // modem status owns the lowest bits when enabled
    for (genvar i = 0; i < DSL_W; i++) begin : g_dsl
        assign eff_word[i] = dsl_en[i] ? dsl_in[i] : shadow[i];
    end

    // each PHY owns a fixed 3-bit field above the modem bits
    for (genvar k = 0; k < NUM_PHY; k++) begin : g_phy
        for (genvar j = 0; j < PHY_W; j++) begin : g_bit
            localparam int POS = PHY_BASE + k * PHY_W + j;
            assign eff_word[POS] = phy_en[k] ? phy_in[k * PHY_W + j] : shadow[POS];
        end
    end

    // remaining bits always come from the host
    if (HW_TOP < WORD_W) begin : g_host
        assign eff_word[WORD_W-1:HW_TOP] = shadow[WORD_W-1:HW_TOP];
    end
endmodule

// File: rtl/sout_shifter.sv
module sout_shifter
    import sout_pkg::*;
#(
    parameter logic [WORD_W-1:0] SHADOW_RST = '1,
    parameter logic [DIV_W-1:0]  HALF_RST   = 8'd4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WORD_W-1:0]     eff_word,
    input  logic [NUM_GROUPS-1:0] grp_en,
    input  logic                  edge_rise,
    input  logic [DIV_W-1:0]      half,
    output logic                  shift_clk,
    output logic                  shift_data,
    output logic                  store_strobe,
    output logic                  busy,
    output logic                  edge_l,
    output logic [DIV_W-1:0]      half_l,
    output logic [WORD_W-1:0]     sent
);
    typedef struct packed {
        eng_state_t        st;
        logic [DIV_W-1:0]  cnt;
        logic              phase;
        logic [BCNT_W-1:0] bits_left;
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] snap;
        logic [WORD_W-1:0] sent;
        logic [DIV_W-1:0]  half_l;
        logic              edge_l;
    } eng_t;

    eng_t eng_d, eng_q;
    logic half_done;

    assign half_done = (eng_q.cnt == eng_q.half_l - 1'b1);

    always_comb begin
        eng_d = eng_q;
        case (eng_q.st)
            ST_IDLE: begin
                if (eff_word != eng_q.sent && grp_en != '0) begin
                    eng_d.st        = ST_SHIFT;
                    eng_d.sr        = pack_groups(eff_word, grp_en);
                    eng_d.snap      = eff_word;
                    eng_d.bits_left = BCNT_W'($countones(grp_en) * GROUP_W);
                    eng_d.cnt       = '0;
                    eng_d.phase     = 1'b0;
                    eng_d.half_l    = half;
                    eng_d.edge_l    = edge_rise;
                end
            end
            ST_SHIFT: begin
                if (half_done) begin
                    eng_d.cnt = '0;
                    if (!eng_q.phase) begin
                        eng_d.phase = 1'b1;
                    end else begin
                        eng_d.phase     = 1'b0;
                        eng_d.sr        = {eng_q.sr[WORD_W-2:0], 1'b0};
                        eng_d.bits_left = eng_q.bits_left - 1'b1;
                        if (eng_q.bits_left == BCNT_W'(1))
                            eng_d.st = ST_STORE;
                    end
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            ST_STORE: begin
                if (half_done) begin
                    eng_d.cnt = '0;
                    if (!eng_q.phase) begin
                        eng_d.phase = 1'b1;
                    end else begin
                        eng_d.phase = 1'b0;
                        eng_d.st    = ST_IDLE;
                        eng_d.sent  = eng_q.snap;
                    end
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q        <= '0;
            eng_q.st     <= ST_IDLE;
            eng_q.sent   <= SHADOW_RST;
            eng_q.snap   <= SHADOW_RST;
            eng_q.half_l <= (HALF_RST == '0) ? DIV_W'(1) : HALF_RST;
        end else begin
            eng_q <= eng_d;
        end
    end

    // phase 0 is the setup half, phase 1 the capture half; polarity inverts
    always_comb begin
        if (eng_q.st == ST_SHIFT)
            shift_clk = eng_q.phase ^ eng_q.edge_l;
        else if (eng_q.st == ST_STORE)
            shift_clk = eng_q.edge_l;
        else
            shift_clk = edge_rise;
    end

    assign shift_data   = eng_q.sr[WORD_W-1];
    assign store_strobe = (eng_q.st == ST_STORE);
    assign busy         = (eng_q.st != ST_IDLE);
    assign edge_l       = eng_q.edge_l;
    assign half_l       = eng_q.half_l;
    assign sent         = eng_q.sent;
endmodule

// File: rtl/sout_expander.sv
module sout_expander
    import sout_pkg::*;
#(
    parameter logic [WORD_W-1:0] SHADOW_RST = '1,
    parameter logic [DIV_W-1:0]  HALF_RST   = 8'd4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [WORD_W-1:0]        reg_wdata,
    output logic [WORD_W-1:0]        reg_rdata,
    input  logic [DSL_W-1:0]         dsl_in,
    input  logic [NUM_PHY*PHY_W-1:0] phy_in,
    output logic                     shift_clk,
    output logic                     shift_data,
    output logic                     store_strobe
);
    logic [WORD_W-1:0] shadow_word;
    logic [WORD_W-1:0] eff_word;
    logic [WORD_W-1:0] sent_word;
    cfg_t              cfg;
    logic              eng_busy;
    logic              eng_edge;
    logic [DIV_W-1:0]  eng_half;

    sout_regs #(
        .SHADOW_RST (SHADOW_RST),
        .HALF_RST   (HALF_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .eff_word (eff_word),
        .rdata    (reg_rdata),
        .shadow   (shadow_word),
        .cfg      (cfg)
    );

    sout_mux u_mux (
        .shadow   (shadow_word),
        .dsl_en   (cfg.dsl_en),
        .phy_en   (cfg.phy_en),
        .dsl_in   (dsl_in),
        .phy_in   (phy_in),
        .eff_word (eff_word)
    );

    sout_shifter #(
        .SHADOW_RST (SHADOW_RST),
        .HALF_RST   (HALF_RST)
    ) u_shifter (
        .clk          (clk),
        .rst_n        (rst_n),
        .eff_word     (eff_word),
        .grp_en       (cfg.grp_en),
        .edge_rise    (cfg.edge_rise),
        .half         (cfg.half),
        .shift_clk    (shift_clk),
        .shift_data   (shift_data),
        .store_strobe (store_strobe),
        .busy         (eng_busy),
        .edge_l       (eng_edge),
        .half_l       (eng_half),
        .sent         (sent_word)
    );
endmodule

// File: rtl/sout_expander_chk.sv
module sout_expander_chk
    import sout_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sclk,
    input logic                  sdata,
    input logic                  sstore,
    input logic                  busy,
    input logic                  edge_l,
    input logic                  cfg_edge,
    input logic [NUM_GROUPS-1:0] cfg_grp,
    input logic [DIV_W-1:0]      half_l,
    input logic [WORD_W-1:0]     eff,
    input logic [WORD_W-1:0]     sent
);
    logic [DIV_W+1:0] st_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st_cnt <= '0;
        else if (sstore) st_cnt <= st_cnt + 1'b1;
        else             st_cnt <= '0;
    end

    // R7
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sclk != $past(sclk) && sclk != edge_l) |-> $stable(sdata));

    // R8
    store_clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sstore |-> (sclk == edge_l));

    // R8
    store_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sstore) |-> (st_cnt == {1'b0, half_l, 1'b0}));

    // R10
    idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg_edge && !sstore));

    // R5
    start_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> $past(eff != sent));

    // R6
    start_needs_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> $past(cfg_grp != '0));
endmodule

bind sout_expander sout_expander_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (shift_clk),
    .sdata    (shift_data),
    .sstore   (store_strobe),
    .busy     (eng_busy),
    .edge_l   (eng_edge),
    .cfg_edge (cfg.edge_rise),
    .cfg_grp  (cfg.grp_en),
    .half_l   (eng_half),
    .eff      (eff_word),
    .sent     (sent_word)
);

// File: tb/sout_expander_bench.sv
module sout_expander_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic [1:0]  dsl_in = 2'b00;
    logic [11:0] phy_in = '0;
    logic        shift_clk, shift_data, store_strobe;

    always #4 clk = ~clk;

    sout_expander u_sout_expander (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dsl_in(dsl_in),
        .phy_in(phy_in), .shift_clk(shift_clk), .shift_data(shift_data),
        .store_strobe(store_strobe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural model of the host-visible state
    logic [23:0] m_shadow = 24'hFFFFFF;
    logic [2:0]  m_grp = 3'b111;
    logic        m_edge = 1'b0;
    logic [1:0]  m_dsl = 2'b00;
    logic [3:0]  m_phy = 4'b0000;
    int          m_half = 4;

    // model of the external register chain
    logic [23:0] casc = '0, latched = '0;
    int nb = 0, last_nb = 0, str_count = 0, st_len = 0, last_st_len = 0;
    int cyc = 0, last_cap = -1000, last_dchg = -1000;
    int period_bad = 0, stable_bad = 0, clk_toggles = 0;
    bit fresh = 1;
    logic prev_clk = 1'b0, prev_data = 1'b0, prev_st = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] m_eff();
        logic [23:0] w;
        w = m_shadow;
        for (int i = 0; i < 2; i++) if (m_dsl[i]) w[i] = dsl_in[i];
        for (int k = 0; k < 4; k++)
            if (m_phy[k]) for (int j = 0; j < 3; j++) w[2 + 3*k + j] = phy_in[3*k + j];
        return w;
    endfunction

    // chain contents expected after shifting: first bit sent ends highest
    function automatic logic [23:0] exp_chain(input logic [23:0] w, input logic [2:0] g);
        bit q[$];
        logic [23:0] r;
        r = '0;
        for (int gi = 2; gi >= 0; gi--)
            if (g[gi]) for (int b = 7; b >= 0; b--) q.push_back(w[8*gi + b]);
        for (int i = 0; i < q.size(); i++) r[q.size() - 1 - i] = q[i];
        return r;
    endfunction

    function automatic int n_bits(input logic [2:0] g);
        return 8 * (int'(g[0]) + int'(g[1]) + int'(g[2]));
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            // R2: address 0 returns the effective word every cycle
            if (reg_addr == 2'd0) check(reg_rdata == m_eff(), "R2", reg_rdata, m_eff());
            // R8: shift clock idle while strobe is high
            if (store_strobe) check(shift_clk == m_edge, "R8", shift_clk, m_edge);
            if (shift_clk != prev_clk) clk_toggles++;
            if (shift_clk != prev_clk && shift_clk != m_edge) begin
                if (!fresh && (cyc - last_cap) != 2 * m_half) period_bad++;
                if ((cyc - last_dchg) < m_half) stable_bad++;
                casc = {casc[22:0], shift_data};
                nb++;
                last_cap = cyc;
                fresh = 0;
            end
            if (shift_data != prev_data) begin
                if ((cyc - last_cap) < m_half) stable_bad++;
                last_dchg = cyc;
            end
            if (store_strobe && !prev_st) begin
                latched = casc; last_nb = nb; nb = 0; str_count++; st_len = 0;
            end
            if (store_strobe) st_len++;
            if (!store_strobe && prev_st) begin last_st_len = st_len; fresh = 1; end
            prev_clk = shift_clk; prev_data = shift_data; prev_st = store_strobe;
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [23:0] v);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = 2'd0;
        if (a == 2'd0) m_shadow = v;
        if (a == 2'd1) begin
            m_grp = v[2:0]; m_edge = v[3]; m_dsl = v[5:4]; m_phy = v[9:6];
            m_half = (v[23:16] == 0) ? 1 : int'(v[23:16]);
        end
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [23:0] v);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
        @(posedge clk); #1;
        reg_addr = 2'd0;
    endtask

    function automatic logic [23:0] cfg_word(input logic [2:0] g, input logic e,
                                             input logic [1:0] d, input logic [3:0] p, input int h);
        return {8'(h), 6'd0, p, d, e, g};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_xfer(input string tag, input int base, input int exp_cnt);
        logic [23:0] mask, expw;
        int eb;
        eb   = n_bits(m_grp);
        mask = (eb >= 24) ? 24'hFFFFFF : ((24'd1 << eb) - 24'd1);
        expw = exp_chain(m_eff(), m_grp);
        check(str_count - base == exp_cnt, {tag, " strobes"}, str_count - base, exp_cnt);
        check(last_nb == eb, {tag, " bits"}, last_nb, eb);
        check((latched & mask) == expw, {tag, " chain"}, latched & mask, expw);
        check(last_st_len == 2 * m_half, "R8 strobe length", last_st_len, 2 * m_half);
        check(period_bad == 0, "R7 bit period", period_bad, 0);
        check(stable_bad == 0, "R7 data stability", stable_bad, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [23:0] v;
        int base;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        read_reg(2'd0, v); check(v == 24'hFFFFFF, "R1 shadow", v, 24'hFFFFFF);
        read_reg(2'd1, v); check(v == 24'h040007, "R1 config", v, 24'h040007);
        wait_cyc(50);
        check(str_count == 0 && clk_toggles == 0, "R1 quiet", str_count + clk_toggles, 0);
        check(shift_clk == 1'b0 && store_strobe == 1'b0, "R1 pins", {shift_clk, store_strobe}, 0);
        read_reg(2'd2, v); check(v == 24'h0, "R2 unused address", v, 0);

        // R5: full three-group transfer
        base = str_count;
        write_reg(2'd0, 24'hA5C33C);
        wait_cyc(600);
        check_xfer("R5 three groups", base, 1);

        // R6: only groups 2 and 0 fitted
        write_reg(2'd1, cfg_word(3'b101, 1'b0, 2'b00, 4'b0000, 4));
        base = str_count;
        write_reg(2'd0, 24'h123456);
        wait_cyc(600);
        check_xfer("R6 two groups", base, 1);
        check(latched[15:0] == 16'h1256, "R6 group order", latched[15:0], 16'h1256);

        // R6: no groups enabled, no activity
        write_reg(2'd1, cfg_word(3'b000, 1'b0, 2'b00, 4'b0000, 4));
        base = str_count; clk_toggles = 0;
        write_reg(2'd0, 24'h0F0F0F);
        wait_cyc(600);
        check(str_count == base && clk_toggles == 0, "R6 no groups", str_count - base + clk_toggles, 0);

        // R7, R10: inverted polarity, half-period 2, pending word goes out
        base = str_count;
        write_reg(2'd1, cfg_word(3'b111, 1'b1, 2'b00, 4'b0000, 2));
        wait_cyc(600);
        check_xfer("R7 rising-edge mode", base, 1);
        check(shift_clk == 1'b1, "R10 idle high", shift_clk, 1);

        // R2: half-period 0 reads back as 1
        write_reg(2'd1, cfg_word(3'b111, 1'b0, 2'b00, 4'b0000, 0));
        read_reg(2'd1, v); check(v == 24'h010007, "R2 half clamp", v, 24'h010007);
        base = str_count;
        write_reg(2'd0, 24'h5A5A5A);
        wait_cyc(600);
        check_xfer("R2 half one", base, 1);
        check(shift_clk == 1'b0, "R10 idle low", shift_clk, 0);

        // R3: modem takeover of the two lowest bits
        write_reg(2'd1, cfg_word(3'b111, 1'b0, 2'b11, 4'b0000, 4));
        dsl_in = 2'b10;
        wait_cyc(600);
        base = str_count;
        @(posedge clk); #1 dsl_in = 2'b01;
        wait_cyc(600);
        read_reg(2'd0, v); check(v[1:0] == 2'b01, "R3 modem bits", v[1:0], 2'b01);
        check_xfer("R3 modem transfer", base, 1);
        write_reg(2'd1, cfg_word(3'b111, 1'b0, 2'b01, 4'b0000, 4));
        wait_cyc(600);
        read_reg(2'd0, v); check(v[1:0] == {m_shadow[1], 1'b1}, "R3 single bit", v[1:0], {m_shadow[1], 1'b1});

        // R4: PHY2 and PHY4 take over bits 5..7 and 11..13
        write_reg(2'd1, cfg_word(3'b111, 1'b0, 2'b00, 4'b1010, 4));
        @(posedge clk); #1 phy_in = 12'hABC;
        wait_cyc(600);
        base = str_count;
        write_reg(2'd0, 24'h000000);
        wait_cyc(600);
        read_reg(2'd0, v);
        check(v[7:5] == phy_in[5:3] && v[13:11] == phy_in[11:9], "R4 phy fields",
              {v[13:11], v[7:5]}, {phy_in[11:9], phy_in[5:3]});
        check(v == m_eff(), "R4 host write ignored", v, m_eff());
        check_xfer("R4 phy transfer", base, 1);

        // R9: changes during a transfer collapse into one more transfer
        write_reg(2'd1, cfg_word(3'b111, 1'b0, 2'b00, 4'b0000, 4));
        wait_cyc(600);
        base = str_count;
        write_reg(2'd0, 24'h111111);
        wait_cyc(30);
        write_reg(2'd0, 24'h222222);
        wait_cyc(30);
        write_reg(2'd0, 24'h3C3C3C);
        wait_cyc(1500);
        check_xfer("R9 latest word", base, 2);

        finish_run();
    end
endmodule